// File: doc/BRIEF.md
# Counter-Driven I2C Byte Shifter

This block moves the data phase of an I2C transfer one bit at a time. It works in both bus roles. Control logic loads an 8-bit shift register, chooses whether the block drives SDA, and writes a bit count. The count decides what happens on SCL. A non-zero count clears the completion flag. As master, the block then generates SCL itself. As slave, the block lets go of an SCL line it was holding low. When the count has been used up, the flag sets. A master stops clocking with SCL low. A slave holds SCL low until the next count write.

Data moves most significant bit first. SDA is sampled into the least significant bit on each SCL rise. The bit being sent is placed on SDA after each SCL fall. A count of 8 moves a full byte in either direction. A count of 1 with output enabled sends a single acknowledge bit: MSB 0 gives ACK and MSB 1 gives NACK. Both bus lines are open-drain. The block only asks for a line to be pulled low, and it reads back the resolved level of the line.

The control inputs are plain single-cycle write strobes with no handshake. A strobe is taken on the clock edge where it is high, and the block never applies back-pressure. Software should write only while SCL is low.

Top module: `i2c_shift_unit`

## Requirements
- R1: After reset, `done_flag` is 0, both pull-low requests are 0 and `rx_data` is 0.
- R2: While `sda_oe` is 0, `sda_pull_low` stays 0, so SDA is only sampled.
- R3: A `cnt_wr` strobe with a non-zero `cnt_wdata` clears `done_flag` on that clock edge.
- R4: In master mode with a non-zero count, each SCL low phase and each unstretched high phase lasts `SCL_DIV` clocks. When the count reaches zero, SCL stays low and no more rises occur.
- R5: After a count of N is written, `done_flag` sets on the first clock edge at which `scl_in` reads low after the Nth rise. Falls that are not preceded by a rise since the write are not counted.
- R6: In slave mode, once `done_flag` is set and SCL reads low, `scl_pull_low` is asserted from the next clock and held. A non-zero count write releases it one clock after the write edge.
- R7: On receive, SDA is sampled on each SCL rise into bit 0 while the register shifts left. After 8 bits, `rx_data` equals the bits sent, first bit in bit 7.
- R8: On transmit, `sda_pull_low` equals `sda_oe` AND NOT of the bit on offer. That bit is bit 7 of the loaded value, and it advances only after an SCL fall. The bus sees the loaded byte MSB first and sees no SDA change while SCL stays high.
- R9: A count of 1 with output enabled sends exactly one bit, equal to bit 7 of the shift register (0 = ACK, 1 = NACK), and then sets `done_flag`.
- R10: Writing a count of 0 leaves `done_flag` as it is. In master mode it produces no SCL rise, and SCL stays low.
- R11: In master mode, the high-phase timer starts only at the first clock edge at which `scl_in` reads high. A partner stretching SCL low therefore lengthens the low phase and leaves the high phase at `SCL_DIV` clocks from that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| master_en | input | 1 | 1 = block generates SCL, 0 = slave role |
| sda_oe | input | 1 | 1 = block may pull SDA low |
| sr_wr | input | 1 | Strobe: load shift register |
| sr_wdata | input | DATA_W | Value loaded by `sr_wr` |
| cnt_wr | input | 1 | Strobe: load bit counter |
| cnt_wdata | input | CNT_W | Bit count loaded by `cnt_wr` |
| rx_data | output | DATA_W | Shift register contents |
| done_flag | output | 1 | Completion flag |
| scl_in | input | 1 | Resolved SCL line level |
| sda_in | input | 1 | Resolved SDA line level |
| scl_pull_low | output | 1 | Request to pull SCL low |
| sda_pull_low | output | 1 | Request to pull SDA low |

## Verification
Each result is due at a fixed number of clocks after the event that causes it:

- The flag sets on the first edge at which the final fall is seen. In master mode, SCL moves from a register, so the flag shows one sampled clock after the bench first sees the line low. In slave mode, the bench moves SCL between edges, so the flag shows in that same sample.
- A slave hold is released one clock after the count write.
- A master high phase covers `SCL_DIV` samples, or one fewer when the bench ends a stretch between edges.

The bench samples on the falling clock edge. It records the sample numbers of line edges and flag rises, and compares their differences with these fixed offsets.

// File: rtl/i2c_su_pkg.sv
package i2c_su_pkg;
  typedef struct packed {
    logic level;
    logic rise;
    logic fall;
  } scl_ev_t;
endpackage

// File: rtl/su_edge.sv
module su_edge
  import i2c_su_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    scl_in,
  output scl_ev_t ev
);
  logic scl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) scl_q <= 1'b1;
    else        scl_q <= scl_in;
  end

  always_comb begin
    ev.level = scl_in;
    ev.rise  = scl_in & ~scl_q;
    ev.fall  = ~scl_in & scl_q;
  end
endmodule

// File: rtl/su_sclgen.sv
module su_sclgen #(
  parameter int SCL_DIV = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic level,
  output logic pull
);
  localparam int TW = (SCL_DIV > 2) ? $clog2(SCL_DIV) : 1;
  localparam logic [TW-1:0] LAST = TW'(SCL_DIV - 1);

  logic [TW-1:0] timer;
  logic          run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timer <= '0;
      run_q <= 1'b0;
      pull  <= 1'b0;
    end else begin
      run_q <= run;
      if (!run) begin
        timer <= '0;
      end else if (!run_q) begin
        pull  <= 1'b1;
        timer <= '0;
      end else if (pull) begin
        if (timer == LAST) begin
          pull  <= 1'b0;
          timer <= '0;
        end else begin
          timer <= timer + 1'b1;
        end
      end else if (!level) begin
        timer <= '0;
      end else if (timer == LAST) begin
        pull  <= 1'b1;
        timer <= '0;
      end else begin
        timer <= timer + 1'b1;
      end
    end
  end

  assert_idle_stays_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && pull) |=> pull);
endmodule

// File: rtl/su_shift.sv
module su_shift
  import i2c_su_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  scl_ev_t           ev,
  input  logic              sda_in,
  input  logic              sr_wr,
  input  logic [DATA_W-1:0] sr_wdata,
  input  logic              cnt_wr,
  input  logic [CNT_W-1:0]  cnt_wdata,
  output logic [DATA_W-1:0] shreg,
  output logic              cnt_nz,
  output logic              flag,
  output logic              out_bit
);
  localparam int MSB = DATA_W - 1;

  logic [CNT_W-1:0] cnt;
  logic             seen_rise;

  assign cnt_nz = (cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '0;
      out_bit <= 1'b1;
    end else if (sr_wr) begin
      shreg   <= sr_wdata;
      out_bit <= sr_wdata[MSB];
    end else begin
      if (ev.rise && cnt_nz) shreg <= {shreg[MSB-1:0], sda_in};
      if (ev.fall) out_bit <= shreg[MSB];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      flag      <= 1'b0;
      seen_rise <= 1'b0;
    end else if (cnt_wr) begin
      cnt       <= cnt_wdata;
      seen_rise <= 1'b0;
      if (cnt_wdata != '0) flag <= 1'b0;
    end else if (cnt_nz) begin
      if (ev.rise) seen_rise <= 1'b1;
      if (ev.fall && seen_rise) begin
        cnt       <= cnt - 1'b1;
        seen_rise <= 1'b0;
        if (cnt == CNT_W'(1)) flag <= 1'b1;
      end
    end
  end

  assert_load_clears_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_wr && cnt_wdata != '0) |=> !flag);
  assert_flag_on_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> !$past(ev.level));
  assert_zero_write_keeps_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_wr && cnt_wdata == '0) |=> (flag == $past(flag)));
endmodule

// File: rtl/i2c_shift_unit.sv
module i2c_shift_unit
  import i2c_su_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int SCL_DIV = 6,
  localparam int CNT_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master_en,
  input  logic              sda_oe,
  input  logic              sr_wr,
  input  logic [DATA_W-1:0] sr_wdata,
  input  logic              cnt_wr,
  input  logic [CNT_W-1:0]  cnt_wdata,
  output logic [DATA_W-1:0] rx_data,
  output logic              done_flag,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              scl_pull_low,
  output logic              sda_pull_low
);
  scl_ev_t ev;
  logic    cnt_nz, flag, out_bit, m_pull, hold_r;

  su_edge u_edge (.clk(clk), .rst_n(rst_n), .scl_in(scl_in), .ev(ev));

  su_shift #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .ev(ev), .sda_in(sda_in),
    .sr_wr(sr_wr), .sr_wdata(sr_wdata), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
    .shreg(rx_data), .cnt_nz(cnt_nz), .flag(flag), .out_bit(out_bit));

  su_sclgen #(.SCL_DIV(SCL_DIV)) u_gen (
    .clk(clk), .rst_n(rst_n), .run(master_en & cnt_nz),
    .level(scl_in), .pull(m_pull));

  // slave clock stretch: latch the hold once SCL is seen low with the flag up
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_r <= 1'b0;
    else        hold_r <= flag & (hold_r | ~scl_in);
  end

  assign scl_pull_low = master_en ? m_pull : hold_r;
  assign sda_pull_low = sda_oe & ~out_bit;
  assign done_flag    = flag;

  assert_slave_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!master_en && flag && !scl_in && !cnt_wr) |=> (scl_pull_low || master_en));
  assert_sda_still_while_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_in && $past(scl_in) && !$past(sr_wr) && $stable(sda_oe)) |-> $stable(sda_pull_low));
endmodule

// File: tb/tb_i2c_shift_unit.sv
module tb_i2c_shift_unit;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 6;
  localparam int P   = 4;

  logic clk = 0, rst_n = 0;
  logic master_en = 0, sda_oe = 0, sr_wr = 0, cnt_wr = 0;
  logic [7:0] sr_wdata = 0;
  logic [3:0] cnt_wdata = 0;
  logic [7:0] rx_data;
  logic done_flag, scl_pull_low, sda_pull_low;
  logic tb_scl_pull = 0, tb_sda_pull = 0;
  wire  scl_line = ~(scl_pull_low | tb_scl_pull);
  wire  sda_line = ~(sda_pull_low | tb_sda_pull);

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_shift_unit #(.DATA_W(8), .SCL_DIV(DIV)) dut (
    .clk(clk), .rst_n(rst_n), .master_en(master_en), .sda_oe(sda_oe),
    .sr_wr(sr_wr), .sr_wdata(sr_wdata), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
    .rx_data(rx_data), .done_flag(done_flag), .scl_in(scl_line), .sda_in(sda_line),
    .scl_pull_low(scl_pull_low), .sda_pull_low(sda_pull_low));

  int total = 0, fails = 0, cyc = 0;
  int rises, falls, target, fall_cyc, flag_cyc, hrun, last_hi, hi_after, stretch_at, st_cnt = 0;
  int drive_err;
  bit scl_prev = 1, flag_prev = 0, ptx = 0;
  logic [7:0] got, ptx_byte;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    bit s;
    @(negedge clk);
    cyc++;
    s = scl_line;
    if (!sda_oe && sda_pull_low) drive_err++;
    if (s && !scl_prev) begin rises++; got = {got[6:0], sda_line}; hrun = 0; end
    if (s) hrun++;
    if (!s && scl_prev && rises > falls) begin
      falls++;
      last_hi = hrun;
      if (falls == target) fall_cyc = cyc;
      if (falls == stretch_at + 1) hi_after = hrun;
      if (falls == stretch_at) begin tb_scl_pull = 1; st_cnt = DIV + 5; end
      if (ptx && falls < 8) tb_sda_pull = ~ptx_byte[7-falls];
    end
    if (done_flag && !flag_prev && flag_cyc < 0) flag_cyc = cyc;
    flag_prev = done_flag;
    scl_prev = s;
    if (st_cnt > 0) begin st_cnt--; if (st_cnt == 0) tb_scl_pull = 0; end
  endtask

  task automatic wr_sr(input logic [7:0] v);
    sr_wdata = v; sr_wr = 1; tick(); sr_wr = 0;
  endtask

  task automatic wr_cnt(input logic [3:0] v);
    cnt_wdata = v; cnt_wr = 1; tick(); cnt_wr = 0;
  endtask

  task automatic slave_clocks(input int n);
    for (int i = 0; i < n; i++) begin
      tb_scl_pull = 1; repeat (P) tick();
      tb_scl_pull = 0;
      for (int t = 0; t < 50 && !scl_line; t++) tick();
      repeat (P) tick();
    end
    tb_scl_pull = 1; repeat (P) tick();
  endtask

  // one transfer; part = byte the bench partner sends when sda_oe is 0
  task automatic run_byte(input bit m, input bit oe, input logic [7:0] sv,
                          input logic [7:0] part, input int nbits, input bit stretch);
    master_en = m; sda_oe = oe;
    if (!m) tb_scl_pull = 1; else tb_scl_pull = 0;
    tick(); tick();
    wr_sr(sv);
    ptx = !oe; ptx_byte = part; tb_sda_pull = !oe && !part[7];
    stretch_at = (stretch && m) ? 3 : -5;
    rises = 0; falls = 0; target = nbits; fall_cyc = -1; flag_cyc = -1; hi_after = -1;
    drive_err = 0; got = 0;
    wr_cnt(4'(nbits));
    chk(done_flag == 0, "R3 flag cleared by count write", done_flag, 0);
    if (!m) begin
      tick();
      chk(scl_pull_low == 0, "R6 hold released after count write", scl_pull_low, 0);
      slave_clocks(nbits);
    end else begin
      for (int t = 0; t < 3000 && !done_flag; t++) tick();
      repeat (3*DIV) tick();
    end
    ptx = 0; tb_sda_pull = 0;
    chk(done_flag == 1, "R5 flag set", done_flag, 1);
    chk(flag_cyc - fall_cyc == (m ? 1 : 0), "R5 flag timing", flag_cyc - fall_cyc, m ? 1 : 0);
    chk(rises == nbits, "R4 clock count", rises, nbits);
    if (!oe) begin
      chk(rx_data == part, "R7 received byte", rx_data, part);
      chk(drive_err == 0, "R2 no SDA drive with output off", drive_err, 0);
    end else if (nbits == 1) begin
      chk(got[0] == sv[7], "R9 ack bit level", got[0], sv[7]);
    end else begin
      chk(got == sv, "R8 transmitted byte", got, sv);
    end
    if (m) begin
      chk(scl_line == 0, "R4 SCL parked low", scl_line, 0);
      if (stretch) chk(hi_after == DIV-1, "R11 high phase after stretch", hi_after, DIV-1);
      else if (nbits > 1) chk(last_hi == DIV, "R4 high phase length", last_hi, DIV);
    end else begin
      tb_scl_pull = 0; repeat (3) tick();
      chk(scl_line == 0, "R6 slave holds SCL", scl_line, 0);
      tb_scl_pull = 1; tick();
    end
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_up();
  end

  initial begin
    int unsigned sd;
    logic [7:0] b;
    sd = $urandom(32'd2024);
    repeat (3) tick();
    chk(done_flag == 0 && scl_pull_low == 0 && sda_pull_low == 0 && rx_data == 0,
        "R1 reset state", {done_flag, scl_pull_low, sda_pull_low}, 0);
    rst_n = 1; tick();
    run_byte(0, 0, 8'h00, 8'hA5, 8, 0);   // slave receive
    run_byte(0, 1, 8'h3C, 8'h00, 8, 0);   // slave transmit
    run_byte(0, 1, 8'h00, 8'h00, 1, 0);   // slave ACK
    run_byte(1, 0, 8'h00, 8'h96, 8, 0);   // master receive
    run_byte(1, 1, 8'h00, 8'h00, 1, 0);   // master ACK
    run_byte(1, 1, 8'hFF, 8'h00, 1, 0);   // master NACK
    run_byte(1, 0, 8'h00, 8'h4B, 8, 1);   // master receive, stretched
    run_byte(1, 1, 8'hC3, 8'h00, 8, 0);   // master transmit
    // R10: zero count write in master mode
    rises = 0;
    wr_cnt(4'd0);
    repeat (4*DIV) tick();
    chk(rises == 0, "R10 no clocks after zero count", rises, 0);
    chk(done_flag == 1, "R10 flag kept", done_flag, 1);
    chk(scl_line == 0, "R10 SCL stays low", scl_line, 0);
    for (int i = 0; i < 10; i++) begin
      b = 8'($urandom);
      case ($urandom % 3)
        0: run_byte(1'($urandom), 0, 8'h00, b, 8, 0);
        1: run_byte(1'($urandom), 1, b, 8'h00, 8, 0);
        default: run_byte(1'($urandom), 1, b, 8'h00, 1, 0);
      endcase
    end
    finish_up();
  end
endmodule